// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This execution unit performs single-step bitfield operations on 64-bit operands. One packed 12-bit control word carries both the field width and the bit offset. An unsigned extract returns the selected field right-justified with zeros above it. A signed extract fills the bits above the field with the field's top bit. An insert clears the field in a container operand and merges the low bits of a source operand into that position. Each of these replaces a sequence of shifts, a mask and an OR.

The control word comes either from an immediate or from the low 12 bits of a register operand. Operations enter through a valid/ready handshake. The result leaves from a single registered output stage, which is controlled by a two-state machine. In state EMPTY, an accepted operation takes transition LOAD into FULL. In state FULL there are three transitions. STREAM stays in FULL when the consumer takes the result and a new operation is accepted in the same cycle. DRAIN returns to EMPTY when the consumer takes the result and no operation arrives. HOLD stays in FULL with the data unchanged while the consumer is not ready.

Top module: `bitfield_unit`

## Requirements
- R1: Control bits [11:6] hold the width code and bits [5:0] hold the offset. A width code of 0 selects a 64-bit field, and any other code selects that many bits.
- R2: For op code 2'b00 (unsigned extract), result bits [w-1:0] equal source bits [o+w-1:o]. All result bits above the field are zero.
- R3: For op code 2'b01 (signed extract), the field is placed as in R2. Every result bit above the field equals the field's top bit.
- R4: For op code 2'b10 (insert), the container bits inside the field are replaced by source bits [w-1:0] placed at the offset. Every container bit outside the field passes through unchanged.
- R5: When offset plus width exceeds 64, the field ends at bit 63. An extract then takes only bits up to 63, and a signed extract uses bit 63 as the sign. An insert then writes no bit above 63, and the source bits beyond the truncated width are dropped.
- R6: With ctl_sel = 0 the control comes from the immediate. With ctl_sel = 1 it comes from bits [11:0] of the control register operand, and that operand's upper bits have no effect.
- R7: An operation accepted at a clock edge (in_valid and in_ready both high) presents its result with out_valid high right after that edge.
- R8: While out_valid is high and out_ready is low, out_data and out_valid hold and in_ready is low.
- R9: During reset and right after it, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 2 | 00 unsigned extract, 01 signed extract, 10 insert |
| in_ctl_sel | input | 1 | 0 immediate control, 1 register control |
| in_imm | input | 12 | Immediate width:offset control |
| in_ctl_reg | input | 64 | Register operand carrying control in bits [11:0] |
| in_src | input | 64 | Source operand |
| in_cont | input | 64 | Container operand for insert |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result |

## Verification
The bench targets three groups of corner cases.

- Width code 0 is the full 64-bit field. A mask built with a plain shift would overflow here and return zero or a one-bit field.
- A field that runs past bit 63 must be truncated. A unit that got this wrong would wrap bits around, take the wrong sign bit, or write past the container.
- Garbage sits in the upper bits of the register-form control. A unit that decoded those bits would move the field.

The bench also holds out_ready low at random. A wrong output stage would then drop, duplicate or change a result under stall, which the in-order scoreboard reports.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
    typedef enum logic [1:0] {
        OP_EXTU = 2'b00,
        OP_EXTS = 2'b01,
        OP_INS  = 2'b10,
        OP_RSVD = 2'b11
    } bfu_op_e;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } bfu_ostate_e;
endpackage

// File: rtl/bfu_ctl_decode.sv
module bfu_ctl_decode #(
    parameter int XLEN = 64,
    localparam int WB  = $clog2(XLEN),
    localparam int CW  = 2 * WB
) (
    input  logic            ctl_sel,
    input  logic [CW-1:0]   imm,
    input  logic [XLEN-1:0] ctl_reg,
    output logic [WB:0]     width,
    output logic [WB-1:0]   offset
);
    logic [CW-1:0] ctl;
    logic [WB-1:0] wcode;

    always_comb begin
        ctl    = ctl_sel ? ctl_reg[CW-1:0] : imm;
        wcode  = ctl[CW-1:WB];
        offset = ctl[WB-1:0];
        width  = (wcode == '0) ? (WB+1)'(XLEN) : {1'b0, wcode};
    end

    always_comb begin
        a_r1_width_range: assert (width != '0 && width <= (WB+1)'(XLEN))
            else $error("width out of range");
    end
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
    parameter int XLEN = 64,
    localparam int WB  = $clog2(XLEN)
) (
    input  logic [WB:0]     width,
    input  logic [WB-1:0]   offset,
    output logic [XLEN-1:0] mask,
    output logic [XLEN-1:0] low_mask,
    output logic [WB-1:0]   top_idx
);
    logic [XLEN-1:0] ones_low;
    logic [WB+1:0]   span_end;

    always_comb begin
        if (width == (WB+1)'(XLEN)) begin
            ones_low = '1;
        end else begin
            ones_low = (XLEN'(1) << width) - XLEN'(1);
        end
        mask     = ones_low << offset;
        low_mask = mask >> offset;
        span_end = {2'b00, offset} + {1'b0, width};
        if (span_end > (WB+2)'(XLEN)) begin
            top_idx = WB'(XLEN - 1);
        end else begin
            top_idx = WB'(span_end - (WB+2)'(1));
        end
    end

    int eff_w;
    always_comb begin
        eff_w = (int'(offset) + int'(width) > XLEN) ? (XLEN - int'(offset)) : int'(width);
        a_r5_mask_count: assert ($countones(mask) == eff_w)
            else $error("mask population wrong");
        a_r5_mask_top: assert (mask[top_idx] == 1'b1)
            else $error("top index not in field");
    end
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
    import bfu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int WB  = $clog2(XLEN)
) (
    input  bfu_op_e         op,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] cont,
    input  logic [XLEN-1:0] mask,
    input  logic [XLEN-1:0] low_mask,
    input  logic [WB-1:0]   offset,
    input  logic [WB-1:0]   top_idx,
    output logic [XLEN-1:0] result
);
    logic [XLEN-1:0] field_r;
    logic [XLEN-1:0] placed;
    logic            sign_bit;

    always_comb begin
        field_r  = (src & mask) >> offset;
        placed   = (src << offset) & mask;
        sign_bit = src[top_idx];
        unique case (op)
            OP_EXTU: result = field_r;
            OP_EXTS: result = field_r | (sign_bit ? ~low_mask : '0);
            OP_INS:  result = (cont & ~mask) | placed;
            default: result = '0;
        endcase
    end

    always_comb begin
        if (op == OP_INS) begin
            a_r4_outside_kept: assert (((result ^ cont) & ~mask) == '0)
                else $error("insert touched bits outside field");
        end
        if (op == OP_EXTU) begin
            a_r2_upper_zero: assert ((result & ~low_mask) == '0)
                else $error("unsigned extract left upper bits");
        end
        if (op == OP_EXTS) begin
            a_r3_sign_fill: assert ((result & ~low_mask) == (sign_bit ? ~low_mask : '0))
                else $error("signed extract fill wrong");
        end
    end
endmodule

// File: rtl/bfu_out_stage.sv
module bfu_out_stage
    import bfu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [XLEN-1:0] in_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_data
);
    bfu_ostate_e     state_q, state_d;
    logic [XLEN-1:0] data_q;
    logic            accept;

    always_comb begin
        in_ready = (state_q == OS_EMPTY) || out_ready;
        accept   = in_valid && in_ready;
        state_d  = state_q;
        unique case (state_q)
            OS_EMPTY: if (accept) state_d = OS_FULL;             // LOAD
            OS_FULL:  if (out_ready && !accept) state_d = OS_EMPTY; // DRAIN; else STREAM/HOLD
            default:  state_d = OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept) begin
            data_q <= in_data;
        end
    end

    assign out_valid = (state_q == OS_FULL);
    assign out_data  = data_q;

    a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid)
        else $error("no result after accept");

    a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("result changed under stall");

    a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready)
        else $error("accepted while stalled");

    a_r9_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready)
        else $error("empty stage not ready");
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int WB  = $clog2(XLEN),
    localparam int CW  = 2 * WB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_op,
    input  logic            in_ctl_sel,
    input  logic [CW-1:0]   in_imm,
    input  logic [XLEN-1:0] in_ctl_reg,
    input  logic [XLEN-1:0] in_src,
    input  logic [XLEN-1:0] in_cont,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_data
);
    logic [WB:0]     width;
    logic [WB-1:0]   offset;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] low_mask;
    logic [WB-1:0]   top_idx;
    logic [XLEN-1:0] result;
    bfu_op_e         op;

    assign op = bfu_op_e'(in_op);

    bfu_ctl_decode #(.XLEN(XLEN)) u_dec (
        .ctl_sel (in_ctl_sel),
        .imm     (in_imm),
        .ctl_reg (in_ctl_reg),
        .width   (width),
        .offset  (offset)
    );

    bfu_mask_gen #(.XLEN(XLEN)) u_mask (
        .width    (width),
        .offset   (offset),
        .mask     (mask),
        .low_mask (low_mask),
        .top_idx  (top_idx)
    );

    bfu_datapath #(.XLEN(XLEN)) u_dp (
        .op       (op),
        .src      (in_src),
        .cont     (in_cont),
        .mask     (mask),
        .low_mask (low_mask),
        .offset   (offset),
        .top_idx  (top_idx),
        .result   (result)
    );

    bfu_out_stage #(.XLEN(XLEN)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (result),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );
endmodule

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = 2'b00;
    logic        in_ctl_sel = 1'b0;
    logic [11:0] in_imm = '0;
    logic [63:0] in_ctl_reg = '0;
    logic [63:0] in_src = '0;
    logic [63:0] in_cont = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    bit rmode = 1'b0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    bitfield_unit u_bitfield_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_ctl_sel(in_ctl_sel), .in_imm(in_imm),
        .in_ctl_reg(in_ctl_reg), .in_src(in_src), .in_cont(in_cont),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_calc(logic [1:0] op, logic [11:0] c,
                                             logic [63:0] s, logic [63:0] k);
        int w;
        int o;
        int ew;
        logic [63:0] r;
        w  = (c[11:6] == 6'd0) ? 64 : int'(c[11:6]);
        o  = int'(c[5:0]);
        ew = (o + w > 64) ? (64 - o) : w;
        if (op == 2'b10) begin
            r = k;
            for (int i = 0; i < ew; i++) r[o+i] = s[i];
        end else begin
            r = '0;
            for (int j = 0; j < ew; j++) r[j] = s[o+j];
            if (op == 2'b01)
                for (int j = ew; j < 64; j++) r[j] = s[o+ew-1];
        end
        return r;
    endfunction

    // Called at posedge+1; returns at posedge+1 after the accepting edge.
    task automatic send(logic [1:0] op, bit sel, logic [11:0] imm, logic [63:0] creg,
                        logic [63:0] src, logic [63:0] cont, string tag);
        bit acc;
        logic [11:0] c;
        in_valid = 1'b1; in_op = op; in_ctl_sel = sel; in_imm = imm;
        in_ctl_reg = creg; in_src = src; in_cont = cont;
        c = sel ? creg[11:0] : imm;
        do begin
            @(negedge clk);
            acc = in_ready;
            if (acc) begin
                exp_q.push_back(ref_calc(op, c, src, cont));
                tag_q.push_back(tag);
            end
            @(posedge clk); #1;
        end while (!acc);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(posedge clk); #1;
    endtask

    // Ready driver
    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = rmode ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    // Monitor / scoreboard
    initial begin
        bit          prev_stall;
        logic [63:0] prev_data;
        logic [63:0] e;
        string       t;
        prev_stall = 1'b0;
        prev_data  = '0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (prev_stall) begin
                    check(out_valid && out_data == prev_data, "R8 hold", out_data, prev_data);
                end
                if (out_valid && !out_ready) begin
                    check(!in_ready, "R8 in_ready low", {63'd0, in_ready}, 64'd0);
                end
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R7 unexpected result", out_data, 64'd0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_data == e, t, out_data, e);
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_data  = out_data;
            end
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [63:0] PAT = 64'hF0E1_D2C3_B4A5_9687;

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid in reset", {63'd0, out_valid}, 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R9 after reset",
              {62'd0, out_valid, in_ready}, 64'd1);
        mon_on = 1'b1;
        @(posedge clk); #1;

        // R7 latency: accept then result right after the edge
        send(2'b00, 1'b0, {6'd11, 6'd12}, '0, PAT, '0, "R2 extu w11 o12");
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R7 valid after accept", {63'd0, out_valid}, 64'd1);
        @(posedge clk); #1;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 drains when idle", {63'd0, out_valid}, 64'd0);
        @(posedge clk); #1;

        send(2'b00, 1'b0, {6'd0, 6'd0}, '0, PAT, '0, "R1 width code 0 full field");
        send(2'b00, 1'b0, {6'd1, 6'd63}, '0, PAT, '0, "R1 width 1 at bit 63");
        send(2'b00, 1'b0, {6'd8, 6'd60}, '0, PAT, '0, "R5 extu truncated");
        send(2'b00, 1'b0, {6'd0, 6'd4}, '0, PAT, '0, "R5 extu full width offset 4");
        send(2'b01, 1'b0, {6'd8, 6'd0}, '0, 64'h0000_0000_0000_0080, '0, "R3 exts negative");
        send(2'b01, 1'b0, {6'd8, 6'd0}, '0, 64'hFFFF_FFFF_FFFF_FF7F, '0, "R3 exts positive");
        send(2'b01, 1'b0, {6'd11, 6'd12}, '0, PAT, '0, "R3 exts w11 o12");
        send(2'b01, 1'b0, {6'd16, 6'd56}, '0, 64'h8000_0000_0000_0000, '0, "R5 exts sign from bit 63");
        send(2'b10, 1'b0, {6'd11, 6'd12}, '0, 64'hFFFF_FFFF_FFFF_F5A5, 64'h1234_5678_9ABC_DEF0, "R4 ins w11 o12");
        send(2'b10, 1'b0, {6'd0, 6'd0}, '0, PAT, 64'h1111_2222_3333_4444, "R4 ins full replace");
        send(2'b10, 1'b0, {6'd16, 6'd56}, '0, 64'hFFFF, 64'h0, "R5 ins truncated");
        send(2'b10, 1'b0, {6'd1, 6'd0}, '0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R4 ins single bit clear");
        send(2'b00, 1'b1, 12'h0, 64'hABCD_0000_0000_0000 | {52'd0, 6'd11, 6'd12}, PAT, '0, "R6 reg control extu");
        send(2'b10, 1'b1, {6'd3, 6'd3}, 64'hFFFF_FFFF_FFFF_F000 | {52'd0, 6'd4, 6'd8}, 64'hF, 64'h0, "R6 reg control ins");
        send(2'b01, 1'b0, {6'd4, 6'd8}, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0F00, '0, "R6 imm ignores reg");
        idle();

        // Random traffic with stalls
        rmode = 1'b1;
        for (int n = 0; n < 300; n++) begin
            logic [1:0]  op;
            logic [63:0] a;
            logic [63:0] b;
            logic [63:0] cr;
            bit          sl;
            op = 2'($urandom % 3);
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            cr = {$urandom, $urandom};
            sl = 1'($urandom % 2);
            send(op, sl, 12'($urandom), cr, a, b,
                 op == 2'b10 ? "R4 random ins" : (op == 2'b01 ? "R3 random exts" : "R2 random extu"));
            if ($urandom % 4 == 0) idle();
        end
        idle();
        rmode = 1'b0;
        for (int k = 0; k < 50 && exp_q.size() != 0; k++) begin
            @(posedge clk); #1;
        end
        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, "R7 all results delivered", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule